// File: doc/BRIEF.md
# Address-Window Execution Histogram

This block watches the stream of instructions a processor retires and builds a histogram of where execution time goes. Software programs a window with a low and a high word address. The block splits the window into a power-of-two number of equal slices and keeps one wide counter, called a bin, for each slice. The block does not stall or otherwise disturb the processor. In instruction mode, each retired instruction that falls inside the window adds one to its bin. In cycle mode, every clock in which profiling runs is charged to the bin of the most recent in-window instruction.

Profiling runs under a two-state machine. `ST_IDLE` moves to `ST_RUN` on a start request: a control write with the enable bit set, or a pulse on `trig_start` without `trig_stop`. `ST_RUN` moves back to `ST_IDLE` on a stop request: a control write with the enable bit clear, or a pulse on `trig_stop`. In all other cycles each state holds.

A register port configures the block. Through the same port, software can stream bins in or out with an auto-incrementing bin pointer. A read returns the whole bin. A write supplies 32 bits. Bin updates pass through a two-stage read-modify-write pipeline that forwards its last result, so back-to-back hits on one bin are all counted. Setting `PTR_W` to 0 removes the counting logic.

Top module: `prof_histogram`

## Requirements
- R1: After reset the machine is in `ST_IDLE`. The control, low, high and pointer registers read 0, and every bin reads 0.
- R2: The register port uses these select codes: 0 control, 1 low bound, 2 high bound, 3 bin pointer, 4 bin data. In the control register, bit 0 is the enable (start when 1, stop when 0) and bit 1 is the mode (0 counts instructions, 1 counts cycles). A control read returns {mode, running} in bits 1:0.
- R3: A `trig_start` pulse starts profiling. A `trig_stop` pulse stops it. When both pulse in the same cycle, the stop wins.
- R4: In instruction mode, each in-window retire while running adds 1 to bin (addr − low) >> S. S is the smallest shift for which (high − low) >> S is less than 2^PTR_W.
- R5: A retire below the low bound, above the high bound, or while stopped changes no bin.
- R6: In cycle mode, each running clock adds 1 to the bin of the latest in-window retire, and the retire cycle itself is charged to the new bin. Clocks before the first in-window retire after a start are not counted.
- R7: A bin saturates at 2^CNT_W − 1 and never wraps.
- R8: A read returns its value with `reg_rvalid` one cycle later. A data read returns the full bin at the pointer. A data write stores the 32-bit write value zero-extended. Each data access advances the pointer by one.
- R9: Hits on the same bin in consecutive cycles are all counted.
- R10: A data write while running is dropped. It leaves both the bin and the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_addr | input | 30 | Word address of the retiring instruction |
| trig_start | input | 1 | Cross-trigger start pulse |
| trig_stop | input | 1 | Cross-trigger stop pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | CNT_W | Read value, registered |
| reg_rvalid | output | 1 | Read value valid |

## Verification
The checker watches the state machine on every cycle: trigger starts and stops, a stop winning over a start, control-write enables, holding when no request is present, pointer stepping, and dropped writes while running. It also checks that `reg_rvalid` follows a read strobe. The count values themselves can only be shown by the bench. It sweeps the window across its edges with several shift values and compares every bin against a histogram computed arithmetically. It also covers repeated back-to-back hits, the cycle-mode charging sequence, zero extension and saturation.

// File: rtl/prof_pkg.sv
package prof_pkg;
    localparam int ADDR_W = 30;
    localparam int WD_W   = 32;

    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_LO   = 3'd1;
    localparam logic [2:0] SEL_HI   = 3'd2;
    localparam logic [2:0] SEL_PTR  = 3'd3;
    localparam logic [2:0] SEL_DATA = 3'd4;

    typedef enum logic {ST_IDLE, ST_RUN} run_state_e;
endpackage

// File: rtl/prof_binmap.sv
module prof_binmap #(
    parameter int PTR_W  = 9,
    parameter int ADDR_W = 30
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              in_win,
    output logic [PTR_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] NBINS = ADDR_W'(1) << PTR_W;

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] off;
    int                msb;
    int                shift;

    always_comb begin
        span = hi - lo;
        off  = addr - lo;
        msb  = 0;
        for (int k = 0; k < ADDR_W; k++) begin
            if (span[k]) msb = k;
        end
        shift  = (span < NBINS) ? 0 : (msb - PTR_W + 1);
        in_win = (addr >= lo) && (addr <= hi);
        idx    = PTR_W'(off >> shift);
    end
endmodule

// File: rtl/prof_bins.sv
module prof_bins #(
    parameter int PTR_W = 9,
    parameter int CNT_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_v,
    input  logic [PTR_W-1:0] ev_idx,
    input  logic             sw_we,
    input  logic [PTR_W-1:0] sw_idx,
    input  logic [CNT_W-1:0] sw_wdata,
    output logic [CNT_W-1:0] sw_rdata
);
    localparam int             NBINS = 1 << PTR_W;
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] mem [NBINS];
    logic             a_v;
    logic [PTR_W-1:0] a_idx;
    logic [CNT_W-1:0] a_dat;
    logic             w_v;
    logic [PTR_W-1:0] w_idx;
    logic [CNT_W-1:0] w_val;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] sum;

    // stage B: pick forwarded value if the write committed at the capture edge hit the same bin
    always_comb begin
        base = (w_v && (w_idx == a_idx)) ? w_val : a_dat;
        sum  = (base == CMAX) ? CMAX : base + 1'b1;
    end

    assign sw_rdata = mem[sw_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBINS; i++) mem[i] <= '0;
            a_v   <= 1'b0;
            a_idx <= '0;
            a_dat <= '0;
            w_v   <= 1'b0;
            w_idx <= '0;
            w_val <= '0;
        end else begin
            a_v   <= ev_v;
            a_idx <= ev_idx;
            a_dat <= mem[ev_idx];
            w_v   <= a_v;
            w_idx <= a_idx;
            w_val <= sum;
            if (a_v) begin
                mem[a_idx] <= sum;
            end else if (sw_we) begin
                mem[sw_idx] <= sw_wdata;
            end
        end
    end
endmodule

// File: rtl/prof_histogram.sv
module prof_histogram #(
    parameter int PTR_W = 9,
    parameter int CNT_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret_valid,
    input  logic [29:0]      ret_addr,
    input  logic             trig_start,
    input  logic             trig_stop,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             reg_rvalid
);
    import prof_pkg::*;

    localparam int PW = (PTR_W > 0) ? PTR_W : 1;

    run_state_e         state, state_nx;
    logic               run_q;
    logic               mode_q;
    logic [ADDR_W-1:0]  lo_q, hi_q;
    logic [PW-1:0]      ptr_q;
    logic               last_v;
    logic [PW-1:0]      last_idx;
    logic               wr_ctrl, start_req, stop_req;
    logic               map_in;
    logic [PW-1:0]      map_idx;
    logic               hit;
    logic               ev_v;
    logic [PW-1:0]      ev_idx;
    logic               sw_we, dat_acc;
    logic [CNT_W-1:0]   bin_rd;

    assign wr_ctrl   = reg_wr && (reg_sel == SEL_CTRL);
    assign start_req = trig_start || (wr_ctrl && reg_wdata[0]);
    assign stop_req  = trig_stop  || (wr_ctrl && !reg_wdata[0]);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start_req && !stop_req) state_nx = ST_RUN;
            ST_RUN:  if (stop_req)               state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs of the state machine: counting events and access gating
    always_comb begin
        run_q  = (state == ST_RUN);
        hit    = ret_valid && map_in;
        ev_v   = 1'b0;
        ev_idx = hit ? map_idx : last_idx;
        unique case (state)
            ST_IDLE: ev_v = 1'b0;
            ST_RUN:  ev_v = mode_q ? (hit || last_v) : hit;
        endcase
        sw_we   = reg_wr && (reg_sel == SEL_DATA) && !run_q;
        dat_acc = (reg_sel == SEL_DATA) && (reg_rd || sw_we);
    end

    generate
        if (PTR_W > 0) begin : g_prof
            prof_binmap #(.PTR_W(PW), .ADDR_W(ADDR_W)) u_map (
                .addr   (ret_addr),
                .lo     (lo_q),
                .hi     (hi_q),
                .in_win (map_in),
                .idx    (map_idx)
            );
            prof_bins #(.PTR_W(PW), .CNT_W(CNT_W)) u_bins (
                .clk      (clk),
                .rst_n    (rst_n),
                .ev_v     (ev_v),
                .ev_idx   (ev_idx),
                .sw_we    (sw_we),
                .sw_idx   (ptr_q),
                .sw_wdata (CNT_W'(reg_wdata)),
                .sw_rdata (bin_rd)
            );
        end else begin : g_none
            assign map_in  = 1'b0;
            assign map_idx = '0;
            assign bin_rd  = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= 1'b0;
            lo_q       <= '0;
            hi_q       <= '0;
            ptr_q      <= '0;
            last_v     <= 1'b0;
            last_idx   <= '0;
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            if (wr_ctrl) mode_q <= reg_wdata[1];
            if (reg_wr && (reg_sel == SEL_LO)) lo_q <= reg_wdata[ADDR_W-1:0];
            if (reg_wr && (reg_sel == SEL_HI)) hi_q <= reg_wdata[ADDR_W-1:0];
            if (reg_wr && (reg_sel == SEL_PTR))  ptr_q <= reg_wdata[PW-1:0];
            else if (dat_acc)                    ptr_q <= ptr_q + 1'b1;
            if (state == ST_IDLE && state_nx == ST_RUN) begin
                last_v <= 1'b0;
            end else if (run_q && hit) begin
                last_v   <= 1'b1;
                last_idx <= map_idx;
            end
            reg_rvalid <= reg_rd;
            if (reg_rd) begin
                unique case (reg_sel)
                    SEL_CTRL: reg_rdata <= CNT_W'({mode_q, run_q});
                    SEL_LO:   reg_rdata <= CNT_W'(lo_q);
                    SEL_HI:   reg_rdata <= CNT_W'(hi_q);
                    SEL_PTR:  reg_rdata <= CNT_W'(ptr_q);
                    SEL_DATA: reg_rdata <= bin_rd;
                    default:  reg_rdata <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/prof_histogram_chk.sv
module prof_histogram_chk #(
    parameter int PW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trig_start,
    input logic          trig_stop,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [2:0]    reg_sel,
    input logic          wen_bit,
    input logic          running,
    input logic [PW-1:0] ptr,
    input logic          reg_rvalid
);
    logic ctrl_wr;
    logic no_req;
    assign ctrl_wr = reg_wr && (reg_sel == 3'd0);
    assign no_req  = !trig_start && !trig_stop && !ctrl_wr;

    AST_TRIG_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        trig_stop |=> !running); // R3
    AST_TRIG_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_start && !trig_stop && !ctrl_wr) |=> running); // R3
    AST_CTRL_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !trig_start && !trig_stop) |=> (running == $past(wen_bit))); // R2
    AST_STATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        no_req |=> $stable(running)); // R2
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_sel == 3'd4) && (reg_rd || (reg_wr && !running))) |=> (ptr == PW'($past(ptr) + 1'b1))); // R8
    AST_RUN_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_sel == 3'd4) && reg_wr && !reg_rd && running) |=> $stable(ptr)); // R10
    AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid); // R8
    AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid); // R8
endmodule

bind prof_histogram prof_histogram_chk #(.PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_start (trig_start),
    .trig_stop  (trig_stop),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_sel    (reg_sel),
    .wen_bit    (reg_wdata[0]),
    .running    (run_q),
    .ptr        (ptr_q),
    .reg_rvalid (reg_rvalid)
);

// File: tb/prof_histogram_test.sv
module prof_histogram_test;
    localparam int NB = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_valid = 1'b0;
    logic [29:0] ret_addr = '0;
    logic        trig_start = 1'b0;
    logic        trig_stop = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [35:0] reg_rdata;
    logic        reg_rvalid;
    logic [31:0] rdata_s;
    logic        rvalid_s;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [35:0] expv [NB];

    always #5 clk = ~clk;

    prof_histogram #(.PTR_W(9), .CNT_W(36)) uut (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_addr(ret_addr),
        .trig_start(trig_start), .trig_stop(trig_stop), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
    );

    prof_histogram #(.PTR_W(9), .CNT_W(32)) uut_sat (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_addr(ret_addr),
        .trig_start(trig_start), .trig_stop(trig_stop), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_s), .reg_rvalid(rvalid_s)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [35:0] v);
        reg_rd = 1'b1; reg_sel = sel;
        @(negedge clk);
        v = reg_rdata;
        chk("R8 rvalid", {35'b0, reg_rvalid}, 36'd1);
        reg_rd = 1'b0;
    endtask

    task automatic retire(input logic [29:0] a);
        ret_valid = 1'b1; ret_addr = a;
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic clear_all();
        wr(3'd3, 32'd0);
        reg_wr = 1'b1; reg_sel = 3'd4; reg_wdata = 32'd0;
        tick(NB);
        reg_wr = 1'b0;
        for (int i = 0; i < NB; i++) expv[i] = '0;
    endtask

    task automatic read_all(input string tag);
        wr(3'd3, 32'd0);
        reg_rd = 1'b1; reg_sel = 3'd4;
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            chk(tag, reg_rdata, expv[i]);
        end
        reg_rd = 1'b0;
    endtask

    function automatic int calc_shift(input logic [29:0] lo, input logic [29:0] hi);
        int s = 0;
        while (((hi - lo) >> s) >= 30'(NB)) s++;
        return s;
    endfunction

    task automatic tally(input logic [29:0] a, input logic [29:0] lo, input logic [29:0] hi);
        if (a >= lo && a <= hi) expv[(a - lo) >> calc_shift(lo, hi)]++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [35:0] v;
        logic [29:0] lo, hi;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        rd(3'd0, v); chk("R1 ctrl", v, 36'd0);
        rd(3'd1, v); chk("R1 low", v, 36'd0);
        rd(3'd2, v); chk("R1 high", v, 36'd0);
        rd(3'd3, v); chk("R1 ptr", v, 36'd0);
        for (int i = 0; i < NB; i++) expv[i] = '0;
        read_all("R1 bins");

        // R8: streaming writes and reads through the pointer
        wr(3'd3, 32'd10);
        wr(3'd4, 32'hDEADBEEF);
        wr(3'd4, 32'h12345678);
        rd(3'd3, v); chk("R8 ptr after writes", v, 36'd12);
        wr(3'd3, 32'd10);
        rd(3'd4, v); chk("R8 read first", v, 36'h0DEADBEEF);
        rd(3'd4, v); chk("R8 read second", v, 36'h012345678);
        rd(3'd3, v); chk("R8 ptr after reads", v, 36'd12);

        // R4 R5 R9: instruction mode sweep, shift 2
        clear_all();
        lo = 30'h100; hi = 30'h8FF;
        wr(3'd1, 32'(lo)); wr(3'd2, 32'(hi));
        retire(30'h200); retire(30'h300);  // R5: stopped, ignored
        wr(3'd0, 32'h1);
        rd(3'd0, v); chk("R2 running instr mode", v, 36'd1);
        for (int a = 'hF0; a <= 'h90F; a++) begin
            ret_valid = 1'b1; ret_addr = 30'(a);
            @(negedge clk);
            tally(30'(a), lo, hi);
        end
        ret_valid = 1'b0;
        tick(3);
        wr(3'd0, 32'h0);
        rd(3'd0, v); chk("R2 stopped", v, 36'd0);
        tick(2);
        read_all("R4 R5 sweep shift2");

        // R3 R9: trigger-started run, shift 0, repeated back-to-back hits
        clear_all();
        lo = 30'd5; hi = 30'd305;
        wr(3'd1, 32'(lo)); wr(3'd2, 32'(hi));
        trig_start = 1'b1; tick(1); trig_start = 1'b0;
        rd(3'd0, v); chk("R3 trigger start", v, 36'd1);
        for (int a = 0; a < 320; a++) begin
            for (int r = 0; r <= a % 3; r++) begin
                ret_valid = 1'b1; ret_addr = 30'(a);
                @(negedge clk);
                tally(30'(a), lo, hi);
            end
        end
        ret_valid = 1'b0;
        tick(3);
        trig_stop = 1'b1; tick(1); trig_stop = 1'b0;
        rd(3'd0, v); chk("R3 trigger stop", v, 36'd0);
        tick(2);
        read_all("R9 back-to-back");

        // R3: simultaneous start and stop, stop wins
        trig_start = 1'b1; trig_stop = 1'b1; tick(1);
        trig_start = 1'b0; trig_stop = 1'b0;
        rd(3'd0, v); chk("R3 stop wins", v, 36'd0);

        // R4: full window, large shift
        clear_all();
        lo = 30'd0; hi = 30'h3FFFFFFF;
        wr(3'd1, 32'(lo)); wr(3'd2, 32'(hi));
        wr(3'd0, 32'h1);
        retire(30'h3FFFFFFF); tally(30'h3FFFFFFF, lo, hi);
        retire(30'h0);        tally(30'h0, lo, hi);
        retire(30'h1FFFFF);   tally(30'h1FFFFF, lo, hi);
        retire(30'h200000);   tally(30'h200000, lo, hi);
        tick(3);
        wr(3'd0, 32'h0);
        tick(2);
        chk("R4 full window top bin", expv[511], 36'd1);
        read_all("R4 full window");

        // R6: cycle mode charging
        clear_all();
        lo = 30'h40; hi = 30'h43F;
        wr(3'd1, 32'(lo)); wr(3'd2, 32'(hi));
        wr(3'd0, 32'h2);
        rd(3'd0, v); chk("R2 mode set while stopped", v, 36'd2);
        trig_start = 1'b1; tick(1); trig_start = 1'b0;
        tick(1);                         // not counted, no retire yet
        retire(30'h40 + 30'd10);         // bin 5
        tick(2);
        retire(30'h10);                  // outside, still bin 5
        tick(1);
        retire(30'h40 + 30'd100);        // bin 50
        tick(2);
        trig_stop = 1'b1; tick(1); trig_stop = 1'b0;
        tick(4);
        expv[5] = 36'd5; expv[50] = 36'd4;
        read_all("R6 cycle mode");

        // R10: data write while running is dropped
        wr(3'd3, 32'd7);
        wr(3'd4, 32'h55);
        wr(3'd0, 32'h1);
        wr(3'd4, 32'hAA);
        rd(3'd3, v); chk("R10 ptr unchanged", v, 36'd8);
        wr(3'd0, 32'h0);
        tick(2);
        wr(3'd3, 32'd7);
        rd(3'd4, v); chk("R10 bin unchanged", v, 36'h55);

        // R7 R8: saturation and zero extension
        lo = 30'd0; hi = 30'd511;
        wr(3'd1, 32'(lo)); wr(3'd2, 32'(hi));
        wr(3'd3, 32'd0);
        wr(3'd4, 32'hFFFFFFFE);
        wr(3'd0, 32'h1);
        retire(30'd0); retire(30'd0); retire(30'd0);
        tick(3);
        wr(3'd0, 32'h0);
        tick(2);
        wr(3'd3, 32'd0);
        rd(3'd4, v);
        chk("R7 wide bin carries past 32 bits", v, 36'h100000001);
        chk("R7 narrow bin saturates", {4'b0, rdata_s}, 36'h0FFFFFFFF);
        wr(3'd3, 32'd0);
        wr(3'd4, 32'hFFFFFFFF);
        wr(3'd3, 32'd0);
        rd(3'd4, v);
        chk("R8 write zero-extends", v, 36'h0FFFFFFFF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule